// File: doc/BRIEF.md
# Frequency Lock-Loss Detector with Hysteresis

This block sits beside each clock and data recovery channel and decides whether the recovered clock is close enough in frequency to the reference for the phase loop to take over. It brings a recovered-clock level into the reference domain through a synchronizer and counts its rising edges over a fixed window of reference cycles. At the end of each window it takes the absolute difference between that count and the expected count, and it compares the result against one of two thresholds. Which threshold applies depends on the present state.

While the block is hunting, the loss-of-lock flag is high and the frequency-acquisition enable stays on, so the oscillator is pulled toward the data rate. A window whose error is below the narrow lock threshold clears the flag and releases the acquisition loop. Once locked, the block keeps measuring. A window whose error is above the wide unlock threshold sets the flag again and restarts acquisition. Errors that fall between the two thresholds leave the state unchanged, so the flag does not chatter.

The thresholds come either from fixed parameter defaults or from configuration inputs. An activity alarm forces the acquisition loop on without touching the lock decision. A soft reset restarts the measurement window and returns the block to the hunting state. It does not change the configuration inputs.

Top module: `freq_lock_det`

## Requirements
- R1: While rst_n is low, and after its release until a window decides otherwise, lol_flag is 1, lol_n is 0 and acq_en is 1.
- R2: From the hunting state (lol_flag=1), a completed window whose edge-count error is strictly below the active lock threshold clears lol_flag.
- R3: From the locked state (lol_flag=0), a completed window whose edge-count error is strictly above the active unlock threshold sets lol_flag.
- R4: An error that lies from the lock threshold up to the unlock threshold, both included, leaves lol_flag unchanged in either state.
- R5: lol_flag changes only at the end of a window of 2**WIN_LOG2 reference cycles (1024 by default). Windows are counted from reset release or from the last cycle that soft_rst was high. A soft reset is the one exception.
- R6: acq_en is the OR of lol_flag and loa_in as registered one cycle earlier. acq_en is therefore 1 whenever loa_in was 1 on the previous cycle.
- R7: lol_n is always the inverse of lol_flag.
- R8: A cycle with soft_rst high gives lol_flag=1 from the next cycle on and restarts the window. The configuration inputs are not altered.
- R9: With cfg_prog_en=0, the thresholds are the defaults DEF_LOCK_THR=16 and DEF_UNLOCK_THR=48, and cfg_lock_thr and cfg_unlock_thr are ignored. With cfg_prog_en=1, the cfg values are used.
- R10: The error is the absolute difference from TARGET_CNT (128). A count below the target is judged the same as a count the same distance above it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Synchronous restart to the hunting state |
| rec_in | input | 1 | Recovered clock (divided) level, asynchronous to clk |
| loa_in | input | 1 | Loss-of-activity alarm, active high |
| cfg_prog_en | input | 1 | 1: use cfg thresholds, 0: use defaults |
| cfg_lock_thr | input | WIN_LOG2+1 | Programmed lock (narrow) threshold |
| cfg_unlock_thr | input | WIN_LOG2+1 | Programmed unlock (wide) threshold |
| lol_flag | output | 1 | Loss of lock, active high |
| lol_n | output | 1 | Loss of lock, active low pin form |
| acq_en | output | 1 | Frequency-acquisition loop enable |

## Verification
The bench drives the recovered level from a phase accumulator, so each window holds a chosen number of edges above or below the target. It then walks the error across both thresholds and back. A design that used a single threshold would drop lock on in-band errors that should have held it. A design that took the signed difference would never unlock on a slow recovered clock. The bench also issues a soft reset at a known cycle and checks that no decision appears before a full window has passed, which a design that did not restart its window counter would violate. It toggles the threshold source while in-band errors are applied, to catch a design that ignored or always used the cfg values.

// File: rtl/flk_pkg.sv
package flk_pkg;

  typedef enum logic {
    ST_HUNT = 1'b0,
    ST_LOCK = 1'b1
  } lock_st_e;

  function automatic logic [31:0] abs_gap(input logic [31:0] a, input logic [31:0] b);
    return (a >= b) ? (a - b) : (b - a);
  endfunction

endpackage

// File: rtl/flk_sync.sv
module flk_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise_pulse
);

  logic [STAGES-1:0] chain;
  logic              prev_q;

  genvar gi;
  generate
    for (gi = 0; gi < STAGES; gi++) begin : g_stage
      if (gi == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= async_in;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[gi] <= 1'b0;
          else        chain[gi] <= chain[gi-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= chain[STAGES-1];
  end

  assign rise_pulse = chain[STAGES-1] & ~prev_q;

endmodule

// File: rtl/flk_meter.sv
module flk_meter #(
  parameter int WIN_LOG2 = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                restart,
  input  logic                edge_pulse,
  output logic                win_done,
  output logic [WIN_LOG2:0]   win_count
);

  localparam int CNT_W = WIN_LOG2 + 1;
  localparam logic [WIN_LOG2-1:0] WIN_LAST = '1;

  logic [WIN_LOG2-1:0] wcnt_q;
  logic [CNT_W-1:0]    ecnt_q;

  assign win_done  = (wcnt_q == WIN_LAST);
  assign win_count = ecnt_q + CNT_W'(edge_pulse);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wcnt_q <= '0;
      ecnt_q <= '0;
    end else if (restart) begin
      wcnt_q <= '0;
      ecnt_q <= '0;
    end else begin
      wcnt_q <= wcnt_q + 1'b1;
      ecnt_q <= win_done ? '0 : win_count;
    end
  end

endmodule

// File: rtl/flk_judge.sv
module flk_judge
  import flk_pkg::*;
#(
  parameter int CNT_W      = 11,
  parameter int TARGET_CNT = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             win_done,
  input  logic [CNT_W-1:0] win_count,
  input  logic [CNT_W-1:0] lock_thr,
  input  logic [CNT_W-1:0] unlock_thr,
  output logic             locked
);

  lock_st_e         st_q, st_d;
  logic [CNT_W-1:0] err;
  logic [31:0]      gap32;

  assign gap32 = abs_gap(32'(win_count), 32'(TARGET_CNT));
  assign err   = gap32[CNT_W-1:0];

  always_comb begin
    st_d = st_q;
    if (win_done) begin
      unique case (st_q)
        ST_HUNT: if (err < lock_thr)   st_d = ST_LOCK;
        ST_LOCK: if (err > unlock_thr) st_d = ST_HUNT;
        default: st_d = ST_HUNT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       st_q <= ST_HUNT;
    else if (restart) st_q <= ST_HUNT;
    else              st_q <= st_d;
  end

  assign locked = (st_q == ST_LOCK);

endmodule

// File: rtl/freq_lock_det.sv
module freq_lock_det #(
  parameter int WIN_LOG2       = 10,
  parameter int TARGET_CNT     = 128,
  parameter int DEF_LOCK_THR   = 16,
  parameter int DEF_UNLOCK_THR = 48,
  parameter int SYNC_STAGES    = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                soft_rst,
  input  logic                rec_in,
  input  logic                loa_in,
  input  logic                cfg_prog_en,
  input  logic [WIN_LOG2:0]   cfg_lock_thr,
  input  logic [WIN_LOG2:0]   cfg_unlock_thr,
  output logic                lol_flag,
  output logic                lol_n,
  output logic                acq_en
);

  localparam int CNT_W = WIN_LOG2 + 1;
  localparam logic [CNT_W-1:0] DEF_LOCK   = CNT_W'(DEF_LOCK_THR);
  localparam logic [CNT_W-1:0] DEF_UNLOCK = CNT_W'(DEF_UNLOCK_THR);

  logic             rec_rise;
  logic             win_done;
  logic [CNT_W-1:0] win_count;
  logic [CNT_W-1:0] lock_sel;
  logic [CNT_W-1:0] unlock_sel;
  logic             locked;
  logic             loa_q;

  flk_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .async_in   (rec_in),
    .rise_pulse (rec_rise)
  );

  flk_meter #(.WIN_LOG2(WIN_LOG2)) u_meter (
    .clk        (clk),
    .rst_n      (rst_n),
    .restart    (soft_rst),
    .edge_pulse (rec_rise),
    .win_done   (win_done),
    .win_count  (win_count)
  );

  assign lock_sel   = cfg_prog_en ? cfg_lock_thr   : DEF_LOCK;
  assign unlock_sel = cfg_prog_en ? cfg_unlock_thr : DEF_UNLOCK;

  flk_judge #(.CNT_W(CNT_W), .TARGET_CNT(TARGET_CNT)) u_judge (
    .clk        (clk),
    .rst_n      (rst_n),
    .restart    (soft_rst),
    .win_done   (win_done),
    .win_count  (win_count),
    .lock_thr   (lock_sel),
    .unlock_thr (unlock_sel),
    .locked     (locked)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) loa_q <= 1'b0;
    else        loa_q <= loa_in;
  end

  assign lol_flag = ~locked;
  assign lol_n    = locked;
  assign acq_en   = ~locked | loa_q;

endmodule

// File: rtl/flk_chk.sv
module flk_chk #(
  parameter int WIN_LOG2 = 10
) (
  input logic clk,
  input logic rst_n,
  input logic soft_rst,
  input logic loa_in,
  input logic lol_flag,
  input logic lol_n,
  input logic acq_en
);

  logic [WIN_LOG2-1:0] ccnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ccnt <= '0;
    else if (soft_rst) ccnt <= '0;
    else               ccnt <= ccnt + 1'b1;
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      assert_reset_state_R1: assert (lol_flag && !lol_n && acq_en)
        else $error("reset state wrong");
    end
  end

  assert_window_edge_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(lol_flag) && !$past(soft_rst)) |-> (ccnt == '0));

  assert_loa_forces_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(loa_in) && $past(rst_n)) |-> acq_en);

  assert_quiet_acq_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !acq_en |-> (!lol_flag && lol_n));

  assert_soft_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (lol_flag && !lol_n && acq_en));

endmodule

bind freq_lock_det flk_chk #(.WIN_LOG2(WIN_LOG2)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .soft_rst (soft_rst),
  .loa_in   (loa_in),
  .lol_flag (lol_flag),
  .lol_n    (lol_n),
  .acq_en   (acq_en)
);

// File: tb/freq_lock_det_tb.sv
module freq_lock_det_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        soft_rst = 1'b0;
  logic        rec_in;
  logic        loa_in = 1'b0;
  logic        cfg_prog_en = 1'b0;
  logic [10:0] cfg_lock_thr = '0;
  logic [10:0] cfg_unlock_thr = '0;
  logic        lol_flag, lol_n, acq_en;

  logic [15:0] acc = '0;
  logic [15:0] inc = 16'd8192;
  int          n_run = 0;
  int          n_fail = 0;
  bit          finished = 1'b0;
  int          st_exp = 0;
  int          prev_d = 0;

  always #5 clk = ~clk;

  always @(negedge clk) acc <= acc + inc;
  assign rec_in = acc[15];

  freq_lock_det u_dut (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .rec_in(rec_in),
    .loa_in(loa_in), .cfg_prog_en(cfg_prog_en), .cfg_lock_thr(cfg_lock_thr),
    .cfg_unlock_thr(cfg_unlock_thr), .lol_flag(lol_flag), .lol_n(lol_n),
    .acq_en(acq_en)
  );

  task automatic chk(input string req, input logic act, input logic expv);
    n_run++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s: actual %0b expected %0b at %0t", req, act, expv, $time);
    end
  endtask

  function automatic int iabs(input int v);
    return (v < 0) ? -v : v;
  endfunction

  // Expected state: 1 locked, 0 hunting, -1 not decidable (count is exact to +/-1)
  function automatic int predict(input int d, input int pd, input int prev, input int lt, input int ut);
    int ae;
    int lo_ae;
    int hi_ae;
    ae = iabs(d);
    if (ae - 1 > ut) return 0;
    if (ae + 1 < lt) return 1;
    if (prev < 0) return -1;
    if (ae - 1 < lt || ae + 1 > ut) return -1;
    hi_ae = (iabs(pd) > ae) ? iabs(pd) : ae;
    lo_ae = ((pd < 0) != (d < 0) && pd != 0) ? 0 : ((iabs(pd) < ae) ? iabs(pd) : ae);
    if (prev == 1) return (hi_ae + 1 <= ut) ? 1 : -1;
    return (lo_ae - 1 >= lt) ? 0 : -1;
  endfunction

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic apply(input int d, input logic loa, input string req);
    int lt;
    int ut;
    lt = cfg_prog_en ? int'(cfg_lock_thr) : 16;
    ut = cfg_prog_en ? int'(cfg_unlock_thr) : 48;
    inc = 16'(8192 + 64 * d);
    loa_in = loa;
    tick(2 * 1024 + 30);
    st_exp = predict(d, prev_d, st_exp, lt, ut);
    prev_d = d;
    if (st_exp >= 0) begin
      chk(req, lol_flag, (st_exp == 0));
      chk("R7", lol_n, (st_exp == 1));
      chk("R6", acq_en, (st_exp == 0) | loa);
    end
  endtask

  initial begin
    int d;
    logic la;
    void'($urandom(32'd20240611));
    tick(3);
    chk("R1", lol_flag, 1'b1);
    chk("R1", lol_n, 1'b0);
    chk("R1", acq_en, 1'b1);
    rst_n = 1'b1;
    tick(20);
    chk("R1", lol_flag, 1'b1);
    st_exp = 0; prev_d = 100;

    // defaults 16/48, cfg junk ignored (R9)
    cfg_lock_thr = 11'd2; cfg_unlock_thr = 11'd3;
    apply(0,   1'b0, "R2");
    apply(30,  1'b0, "R4");
    apply(60,  1'b0, "R3");
    apply(30,  1'b0, "R4");
    apply(10,  1'b0, "R2");
    apply(-60, 1'b0, "R10");
    apply(-30, 1'b0, "R4");
    apply(-10, 1'b0, "R10");
    apply(-30, 1'b0, "R9");

    // programmed thresholds (R9)
    cfg_lock_thr = 11'd6; cfg_unlock_thr = 11'd12;
    cfg_prog_en = 1'b1;
    apply(9,  1'b0, "R4");
    apply(20, 1'b0, "R9");
    apply(9,  1'b0, "R4");
    apply(0,  1'b0, "R2");

    // activity alarm while locked (R6)
    loa_in = 1'b1;
    tick(2);
    chk("R6", acq_en, 1'b1);
    chk("R6", lol_flag, 1'b0);
    loa_in = 1'b0;
    tick(2);
    chk("R6", acq_en, 1'b0);

    // soft reset while locked (R8, R5)
    soft_rst = 1'b1;
    tick(1);
    soft_rst = 1'b0;
    chk("R8", lol_flag, 1'b1);
    chk("R8", acq_en, 1'b1);
    tick(1000);
    chk("R5", lol_flag, 1'b1);
    tick(40);
    chk("R5", lol_flag, 1'b0);
    chk("R8", cfg_prog_en, 1'b1);
    st_exp = 1; prev_d = 0;

    // constrained random with fixed thresholds
    cfg_lock_thr = 11'd20; cfg_unlock_thr = 11'd60;
    for (int i = 0; i < 34; i++) begin
      d  = int'($urandom_range(0, 160)) - 80;
      la = ($urandom_range(0, 3) == 0);
      apply(d, la, (iabs(d) > 60) ? "R3" : ((iabs(d) < 20) ? "R2" : "R4"));
    end

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!finished) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule